// File: doc/BRIEF.md
# Not-Recently-Used Replacement Unit

This block chooses eviction ways for an N-way set-associative cache. It keeps one age flag per cache block. A flag of 1 marks the block as a candidate for eviction. A flag of 0 marks a block that was touched since its set was last swept. The cache controller reports every hit and every fill as a reference, giving the set and the way, and the block clears that way's flag. When the controller needs room in a set, it raises a victim request with the set index. In the same cycle, the block answers with the lowest-numbered way whose flag is 1.

If no block in the requested set is a candidate, the block sweeps that set. Every flag in the set is raised to 1 at the next clock edge, and way 0 is named as the victim, in the manner of a clock algorithm. After reset every flag is 1, so an empty set fills from way 0 upward as long as each victim is filled in the cycle after it is named. Tags, data storage and miss handling belong to the surrounding cache.

Top module: `nru_repl_unit`

## Requirements
- R1: After reset every flag of every set is 1, so the first victim request on any set returns way 0.
- R2: A reference (hit or fill) with `ref_valid_i` high clears the flag of `ref_way_i` in set `ref_set_i` at the next clock edge. A fill of a named victim in the following cycle therefore removes that way from the candidates.
- R3: A reference changes no other way of its set and no flag of any other set.
- R4: While a victim request is active and the requested set holds at least one flag at 1, `vic_way_o` is the lowest-numbered way with flag 1, and the request itself leaves the flags of that set unchanged.
- R5: While a victim request is active and every flag of the requested set is 0, `vic_way_o` is 0 and all flags of that set become 1 at the next clock edge. Way 0 stays a candidate until it is referenced.
- R6: `vic_way_o` is produced combinationally in the same cycle as `vic_req_i`, from the flags as they stand before that cycle's clock edge.
- R7: When a sweep and a reference hit the same set in one cycle, the sweep is applied first and the reference second. The set ends with all flags at 1 except the referenced way.
- R8: While `vic_req_i` is low, `vic_way_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_valid_i | input | 1 | A hit or fill reference is presented this cycle |
| ref_set_i | input | SET_W | Set index of the reference |
| ref_way_i | input | WAY_W | Way index of the reference |
| vic_req_i | input | 1 | Victim request for `vic_set_i` this cycle |
| vic_set_i | input | SET_W | Set index of the victim request |
| vic_way_o | output | WAY_W | Chosen victim way; 0 when no request is active |

## Verification
The bench goes after four corner cases:
- The sweep of a fully referenced set. A design that picked a way other than 0, or that failed to raise the other flags, would return the wrong way on the next request.
- The repeat request right after a sweep. A design that cleared way 0's flag as part of the sweep would move on to way 1 too early.
- A reference and a sweep on the same set in one cycle. Applying them in the wrong order would leave the referenced way marked as a candidate, or leave the other ways at 0.
- References to neighbouring sets and ways. A design that decoded the set or way index wrongly would disturb flags it should not touch.

Long random runs confined to a few sets force many sweeps, which exposes any slip in the priority order.

// File: rtl/nru_pkg.sv
package nru_pkg;

  localparam int unsigned MAX_WAYS = 64;

  typedef logic [MAX_WAYS-1:0] wide_row_t;

  // Mask with every bit below position 'way' set.
  function automatic wide_row_t below_mask(input int unsigned way);
    wide_row_t one;
    one = wide_row_t'(1);
    return (one << way) - one;
  endfunction

  // Mask with the lowest n_ways bits set.
  function automatic wide_row_t ones_mask(input int unsigned n_ways);
    return below_mask(n_ways);
  endfunction

  // Next value of one set's flags: the sweep is applied first, then the reference clear.
  function automatic wide_row_t row_next(
    input wide_row_t   cur,
    input logic        sweep,
    input logic        clr,
    input int unsigned clr_way,
    input int unsigned n_ways
  );
    wide_row_t nxt;
    nxt = cur;
    if (sweep) nxt = ones_mask(n_ways);
    if (clr)   nxt[clr_way] = 1'b0;
    return nxt;
  endfunction

endpackage

// File: rtl/nru_bit_array.sv
module nru_bit_array
  import nru_pkg::*;
#(
  parameter int unsigned NUM_SETS = 64,
  parameter int unsigned NUM_WAYS = 8,
  localparam int unsigned SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int unsigned WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SET_W-1:0]    rd_set_i,
  output logic [NUM_WAYS-1:0] rd_row_o,
  input  logic                sweep_en_i,
  input  logic [SET_W-1:0]    sweep_set_i,
  input  logic                clr_en_i,
  input  logic [SET_W-1:0]    clr_set_i,
  input  logic [WAY_W-1:0]    clr_way_i
);

  logic [NUM_WAYS-1:0] row_q [NUM_SETS];
  logic [NUM_WAYS-1:0] row_d [NUM_SETS];

  always_comb begin
    for (int s = 0; s < NUM_SETS; s++) begin
      row_d[s] = NUM_WAYS'(row_next(
                   wide_row_t'(row_q[s]),
                   sweep_en_i && (sweep_set_i == SET_W'(s)),
                   clr_en_i   && (clr_set_i   == SET_W'(s)),
                   int'(clr_way_i),
                   NUM_WAYS));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) row_q[s] <= '1;
    end else begin
      for (int s = 0; s < NUM_SETS; s++) row_q[s] <= row_d[s];
    end
  end

  assign rd_row_o = row_q[rd_set_i];

  // R2: a referenced way reads 0 after the edge
  assert_ref_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en_i |=> row_q[$past(clr_set_i)][$past(clr_way_i)] == 1'b0);

  // R5: a sweep with no reference to that set leaves all flags at 1
  assert_sweep_fills_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_en_i && !(clr_en_i && clr_set_i == sweep_set_i))
      |=> row_q[$past(sweep_set_i)] == {NUM_WAYS{1'b1}});

  // R7: the sweep goes first, then the clear
  assert_sweep_then_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_en_i && clr_en_i && clr_set_i == sweep_set_i)
      |=> row_q[$past(sweep_set_i)] ==
          ~(NUM_WAYS'(1) << $past(clr_way_i)));

endmodule

// File: rtl/nru_victim_pick.sv
module nru_victim_pick #(
  parameter int unsigned NUM_WAYS = 8,
  localparam int unsigned WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic [NUM_WAYS-1:0] row_i,
  input  logic                req_i,
  output logic [WAY_W-1:0]    way_o,
  output logic                any_cand_o,
  output logic                sweep_o
);

  logic [NUM_WAYS:0]   seen;
  logic [NUM_WAYS-1:0] first;
  logic [WAY_W-1:0]    way_enc;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < NUM_WAYS; i++) begin : g_prio
    assign seen[i+1] = seen[i] | row_i[i];
    assign first[i]  = row_i[i] & ~seen[i];
  end

  always_comb begin
    way_enc = '0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (first[i]) way_enc = way_enc | WAY_W'(i);
    end
  end

  assign any_cand_o = seen[NUM_WAYS];
  assign way_o      = req_i ? way_enc : '0;
  assign sweep_o    = req_i & ~seen[NUM_WAYS];

endmodule

// File: rtl/nru_repl_unit.sv
module nru_repl_unit
  import nru_pkg::*;
#(
  parameter int unsigned NUM_SETS = 64,
  parameter int unsigned NUM_WAYS = 8,
  localparam int unsigned SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int unsigned WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_valid_i,
  input  logic [SET_W-1:0] ref_set_i,
  input  logic [WAY_W-1:0] ref_way_i,
  input  logic             vic_req_i,
  input  logic [SET_W-1:0] vic_set_i,
  output logic [WAY_W-1:0] vic_way_o
);

  // named internal events
  logic [NUM_WAYS-1:0] vic_row;
  logic                cand_any;
  logic                sweep_evt;
  logic                clr_evt;

  assign clr_evt = ref_valid_i;

  nru_bit_array #(
    .NUM_SETS (NUM_SETS),
    .NUM_WAYS (NUM_WAYS)
  ) u_bits (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_set_i    (vic_set_i),
    .rd_row_o    (vic_row),
    .sweep_en_i  (sweep_evt),
    .sweep_set_i (vic_set_i),
    .clr_en_i    (clr_evt),
    .clr_set_i   (ref_set_i),
    .clr_way_i   (ref_way_i)
  );

  nru_victim_pick #(
    .NUM_WAYS (NUM_WAYS)
  ) u_pick (
    .row_i      (vic_row),
    .req_i      (vic_req_i),
    .way_o      (vic_way_o),
    .any_cand_o (cand_any),
    .sweep_o    (sweep_evt)
  );

  // R4: the chosen way is a candidate and no lower way is
  assert_lowest_cand_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_req_i && cand_any) |->
      (vic_row[vic_way_o] == 1'b1) &&
      ((wide_row_t'(vic_row) & below_mask(int'(vic_way_o))) == '0));

  // R4: a request on a set with candidates and no reference leaves that set unchanged
  assert_req_keeps_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_req_i && cand_any && !(ref_valid_i && ref_set_i == vic_set_i))
      ##1 (vic_set_i == $past(vic_set_i)) |-> vic_row == $past(vic_row));

  // R5: a sweep always names way 0
  assert_sweep_way0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_evt |-> vic_way_o == '0);

  // R8: the output is quiet without a request
  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !vic_req_i |-> vic_way_o == '0);

endmodule

// File: tb/nru_repl_unit_tb.sv
`timescale 1ns/1ps
module nru_repl_unit_tb;

  localparam int NS = 64;
  localparam int NW = 8;
  localparam int SW = 6;
  localparam int WW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ref_valid;
  logic [SW-1:0] ref_set;
  logic [WW-1:0] ref_way;
  logic          vic_req;
  logic [SW-1:0] vic_set;
  logic [WW-1:0] vic_way;

  int total = 0;
  int bad   = 0;
  int mdl [NS][NW];
  bit done  = 1'b0;

  always #2 clk = ~clk;

  nru_repl_unit #(.NUM_SETS(NS), .NUM_WAYS(NW)) u_dut (
    .clk (clk), .rst_n (rst_n),
    .ref_valid_i (ref_valid), .ref_set_i (ref_set), .ref_way_i (ref_way),
    .vic_req_i (vic_req), .vic_set_i (vic_set), .vic_way_o (vic_way)
  );

  // Model pick: scan for the first candidate; when none is left, report a sweep and return 0.
  function automatic int mdl_pick(int s, output bit swept);
    swept = 1'b1;
    for (int w = 0; w < NW; w++) begin
      if (mdl[s][w] == 1) begin
        swept = 1'b0;
        return w;
      end
    end
    return 0;
  endfunction

  task automatic step(bit rv, int rs, int rw, bit vv, int vs, string tag);
    int  exp_way;
    bit  swept;
    @(negedge clk);
    ref_valid = rv;
    ref_set   = SW'(rs);
    ref_way   = WW'(rw);
    vic_req   = vv;
    vic_set   = SW'(vs);
    #1;
    swept   = 1'b0;
    exp_way = vv ? mdl_pick(vs, swept) : 0;
    total++;
    if (int'(vic_way) != exp_way) begin
      bad++;
      $display("FAIL %s: vic_way actual=%0d expected=%0d (set %0d)", tag, vic_way, exp_way, vs);
    end
    @(posedge clk);
    if (vv && swept) for (int w = 0; w < NW; w++) mdl[vs][w] = 1;
    if (rv) mdl[rs][rw] = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ref_valid = 0; ref_set = '0; ref_way = '0; vic_req = 0; vic_set = '0;
    for (int s = 0; s < NS; s++) for (int w = 0; w < NW; w++) mdl[s][w] = 1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state, every set starts with way 0
    step(0, 0, 0, 1, 0,  "R1");
    step(0, 0, 0, 1, 5,  "R1");
    step(0, 0, 0, 1, 63, "R1");
    // R8: idle output
    step(0, 0, 0, 0, 7,  "R8");

    // R6 / R2: request, then fill the named way the next cycle; set 10 fills upward
    for (int k = 0; k < NW; k++) begin
      step(0, 0, 0, 1, 10, "R6");
      step(1, 10, k, 0, 0, "R2");
    end
    // R5: full set sweeps to way 0, then way 0 stays the choice until filled
    step(0, 0, 0, 1, 10, "R5");
    step(0, 0, 0, 1, 10, "R5");
    step(1, 10, 0, 0, 0, "R2");
    step(0, 0, 0, 1, 10, "R5");

    // R2: hits skip referenced ways; victim becomes way 2
    step(1, 20, 0, 0, 0, "R2");
    step(1, 20, 1, 0, 0, "R2");
    step(1, 20, 3, 0, 0, "R2");
    step(0, 0, 0, 1, 20, "R4");

    // R3: references elsewhere leave set 22 alone
    step(1, 21, 0, 0, 0, "R3");
    step(1, 23, 0, 0, 0, "R3");
    step(1, 22, 1, 0, 0, "R3");
    step(0, 0, 0, 1, 22, "R3");

    // R7: sweep and reference on the same set in one cycle
    for (int k = 0; k < NW; k++) step(1, 30, k, 0, 0, "R2");
    step(1, 30, 0, 1, 30, "R7");
    step(0, 0, 0, 1, 30, "R7");
    step(1, 31, 5, 1, 31, "R7");
    step(0, 0, 0, 1, 31, "R7");

    // R4: random mix over a few sets to force frequent sweeps
    for (int n = 0; n < 3000; n++) begin
      step(bit'($urandom_range(0, 1)), int'($urandom_range(0, 3)), int'($urandom_range(0, NW - 1)),
           bit'($urandom_range(0, 1)), int'($urandom_range(0, 3)), "R4");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule